// File: doc/BRIEF.md
# Wrapping Four-Beat Burst Address Generator

This block produces the address sequence for a synchronous memory that serves four-word bursts. On a load cycle it captures a full word address from the external bus. Each following cycle without a load steps to the next beat of the burst. The bits above the two least significant bits keep the captured value for the whole burst. The two low bits follow one of two wrapping orders. A static configuration input selects the order. In linear order the beat count is added modulo four to the start offset. In interleaved order the start offset is XORed with the beat count.

A hold input freezes the generator completely. On a held edge the address and the beat index keep their values, even when a load is requested on that edge. The outputs come straight from registers. They show the captured address in the cycle after a load, and the next burst address in the cycle after each advance. A synchronous reset clears all state. The memory array, the data paths and the command decoding lie outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: A clock edge with `rst` high sets `addr_o` to zero and `beat_o` to zero, whatever the other inputs are.
- R2: An edge with `load_i` high, `hold_i` low and `rst` low makes `addr_o` equal to the `ext_addr_i` value present at that edge, and sets `beat_o` to 0. This holds for loads on consecutive cycles too.
- R3: On an advance edge (`load_i`, `hold_i` and `rst` all low), bits `addr_o[ADDR_W-1:2]` keep their value.
- R4: With `interleave_i` low (linear order), the low bits are `addr_o[1:0] = (S + b) mod 4`. Here S is the low two bits that were loaded and b is the value of `beat_o`.
- R5: With `interleave_i` high (interleaved order), the low bits are `addr_o[1:0] = S XOR b`.
- R6: After four advances `beat_o` wraps to 0 and `addr_o` returns to the loaded address. Further advances repeat the same four-address sequence.
- R7: An edge with `hold_i` high and `rst` low leaves `addr_o` and `beat_o` unchanged, even when `load_i` is high on that edge.
- R8: Each advance edge increments `beat_o` by one, modulo 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_i | input | 1 | When high, the edge is ignored and all state is kept |
| load_i | input | 1 | High: capture `ext_addr_i`. Low: advance to the next beat |
| interleave_i | input | 1 | Static order select: 1 for interleaved, 0 for linear |
| ext_addr_i | input | ADDR_W | External word address |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Index of the current beat within the burst |

## Verification
The hardest case to reach is a hold that falls in the middle of a burst that has already wrapped, with a load requested on the same edge. That one edge tests both the freeze and the wrap. The stimulus covers each order with every start offset and several upper-bit patterns. Each burst runs for nine advances, so it wraps twice. A hold edge with a competing load and a different external address is inserted after the fifth advance. Every beat is then compared with the address computed from the start offset and the beat count. Loads on back-to-back cycles and a reset applied in the middle of a burst complete the coverage.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
    localparam int OFS_W = 2;

    typedef logic [OFS_W-1:0] ofs_t;
    typedef logic [OFS_W-1:0] beat_t;

    typedef enum logic {
        SEQ_LINEAR = 1'b0,
        SEQ_XOR    = 1'b1
    } seq_mode_e;
endpackage

// File: rtl/burst_order.sv
module burst_order
    import burst_addr_pkg::*;
(
    input  ofs_t      start_i,
    input  beat_t     beat_i,
    input  seq_mode_e mode_i,
    output ofs_t      ofs_o
);
    always_comb begin
        unique case (mode_i)
            SEQ_XOR:    ofs_o = start_i ^ beat_i;
            default:    ofs_o = start_i + beat_i;
        endcase
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_i,
    input  logic              load_i,
    input  logic              interleave_i,
    input  logic [ADDR_W-1:0] ext_addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        beat_o
);
    localparam int UP_W = ADDR_W - OFS_W;

    typedef struct packed {
        logic [UP_W-1:0] upper;
        ofs_t            start;
        beat_t           beat;
        ofs_t            low;
    } gen_state_t;

    gen_state_t st_d, st_q;
    beat_t      beat_inc;
    ofs_t       low_nxt;

    assign beat_inc = st_q.beat + beat_t'(1);

    burst_order u_order (
        .start_i (st_q.start),
        .beat_i  (beat_inc),
        .mode_i  (seq_mode_e'(interleave_i)),
        .ofs_o   (low_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (!hold_i) begin
            if (load_i) begin
                st_d.upper = ext_addr_i[ADDR_W-1:OFS_W];
                st_d.start = ext_addr_i[OFS_W-1:0];
                st_d.low   = ext_addr_i[OFS_W-1:0];
                st_d.beat  = '0;
            end else begin
                st_d.beat = beat_inc;
                st_d.low  = low_nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign addr_o = {st_q.upper, st_q.low};
    assign beat_o = st_q.beat;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              hold_i,
    input logic              load_i,
    input logic              interleave_i,
    input logic [ADDR_W-1:0] ext_addr_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [1:0]        beat_o
);
    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (load_i && !hold_i) |=> (addr_o == $past(ext_addr_i)) && (beat_o == 2'd0)); // R2

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !hold_i) |=> $stable(addr_o[ADDR_W-1:2])); // R3

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !hold_i && !interleave_i) |=> (addr_o[1:0] - $past(addr_o[1:0])) == 2'd1); // R4

    AST_XOR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !hold_i && interleave_i) |=>
            (addr_o[1:0] ^ $past(addr_o[1:0])) == (beat_o ^ $past(beat_o))); // R5

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> $stable(addr_o) && $stable(beat_o)); // R7

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !hold_i) |=> beat_o == $past(beat_o) + 2'd1); // R8
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .hold_i       (hold_i),
    .load_i       (load_i),
    .interleave_i (interleave_i),
    .ext_addr_i   (ext_addr_i),
    .addr_o       (addr_o),
    .beat_o       (beat_o)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hold_i = 1'b0;
    logic          load_i = 1'b0;
    logic          interleave_i = 1'b0;
    logic [AW-1:0] ext_addr_i = '0;
    logic [AW-1:0] addr_o;
    logic [1:0]    beat_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
        .clk          (clk),
        .rst          (rst),
        .hold_i       (hold_i),
        .load_i       (load_i),
        .interleave_i (interleave_i),
        .ext_addr_i   (ext_addr_i),
        .addr_o       (addr_o),
        .beat_o       (beat_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [AW-1:0] got_a, input logic [AW-1:0] exp_a,
                       input logic [1:0] got_b, input logic [1:0] exp_b);
        checks++;
        if (got_a !== exp_a || got_b !== exp_b) begin
            errors++;
            $display("FAIL %s addr=%h beat=%0d expected addr=%h beat=%0d",
                     tag, got_a, got_b, exp_a, exp_b);
        end
    endtask

    function automatic logic [1:0] exp_low(input logic m, input logic [1:0] s, input int k);
        logic [1:0] b = 2'(k % 4);
        return m ? (s ^ b) : 2'((int'(s) + k) % 4);
    endfunction

    initial begin
        logic [AW-3:0] ups [3];
        ups[0] = '0;
        ups[1] = '1;
        ups[2] = 16'h5A5A;

        // R1: reset clears state even with a load requested
        load_i = 1'b1;
        ext_addr_i = 18'h3FFFF;
        tick();
        tick();
        chk("R1 reset", addr_o, '0, beat_o, 2'd0);
        rst = 1'b0;
        load_i = 1'b0;

        for (int m = 0; m < 2; m++) begin
            interleave_i = m[0];
            for (int s = 0; s < 4; s++) begin
                for (int u = 0; u < 3; u++) begin
                    logic [AW-1:0] base;
                    base = {ups[u], 2'(s)};
                    ext_addr_i = base;
                    load_i = 1'b1;
                    tick();
                    chk("R2 load", addr_o, base, beat_o, 2'd0);
                    load_i = 1'b0;
                    ext_addr_i = ~base;
                    for (int k = 1; k <= 9; k++) begin
                        tick();
                        if (m == 1)
                            chk("R5 R3 R8 R6 interleaved beat", addr_o,
                                {ups[u], exp_low(1'b1, 2'(s), k)}, beat_o, 2'(k % 4));
                        else
                            chk("R4 R3 R8 R6 linear beat", addr_o,
                                {ups[u], exp_low(1'b0, 2'(s), k)}, beat_o, 2'(k % 4));
                        if (k == 5) begin
                            hold_i = 1'b1;
                            load_i = 1'b1;
                            tick();
                            chk("R7 hold with load", addr_o,
                                {ups[u], exp_low(m[0], 2'(s), k)}, beat_o, 2'(k % 4));
                            hold_i = 1'b0;
                            load_i = 1'b0;
                        end
                    end
                end
            end
        end

        // R2: back-to-back loads
        interleave_i = 1'b0;
        load_i = 1'b1;
        ext_addr_i = 18'h12342;
        tick();
        chk("R2 back-to-back first", addr_o, 18'h12342, beat_o, 2'd0);
        ext_addr_i = 18'h2ABC1;
        tick();
        chk("R2 back-to-back second", addr_o, 18'h2ABC1, beat_o, 2'd0);
        load_i = 1'b0;
        tick();
        chk("R4 after reload", addr_o, 18'h2ABC2, beat_o, 2'd1);

        // R1: reset in the middle of a burst
        rst = 1'b1;
        tick();
        chk("R1 mid-burst reset", addr_o, '0, beat_o, 2'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule